// File: doc/BRIEF.md
# Timer Snapshot Read Latch

This block sits on the read path of a 16-bit down-counter that a host reaches over an 8-bit bus. In normal operation a host read of either of the timer's two data addresses returns a byte of the preset value that the counter reloads from. The host asks for the live count by writing 1 to a read bit in the timer control register. The block then waits for a clock cycle in which the counter does not decrement and captures the whole count into two byte-wide snapshot registers at that edge. Because of this, a snapshot can never catch the counter halfway through a change.

While a snapshot is held, reads of the two data addresses return its bytes. A read of the low byte clears the read bit on the following edge, and later reads return the preset again. A read of the high byte leaves the snapshot in place. The host therefore reads the high byte first and the low byte last. A controller has three states. `ST_IDLE` means the read bit is clear. `ST_ARMED` means the read bit is set but nothing has been captured yet. `ST_HELD` means a snapshot is held. The transitions are: arm on a control write of 1 (any state to `ST_ARMED`); capture on a quiet counter cycle (`ST_ARMED` to `ST_HELD`); release on a low-byte read (`ST_HELD` to `ST_IDLE`); and abort on a control write of 0 (any state to `ST_IDLE`).

Top module: `timer_snap_read`

## Requirements
- R1: After reset the controller is in `ST_IDLE`, and both `read_armed` and `snap_valid` are 0.
- R2: When no snapshot is held, a read of `rd_addr` = LO_ADDR (default 0x0F) returns `preset[7:0]`, and a read of LO_ADDR+1 (0x10) returns `preset[15:8]`.
- R3: A cycle with `ctl_we`=1 and `ctl_read_bit`=1 makes `read_armed` 1 from the next cycle, in any state (`ST_ARMED`).
- R4: In `ST_ARMED`, the snapshot is taken at the first edge at which `dec_en` is 0 and there is no control write. It equals `live_count` in that cycle, and `snap_valid` rises after that edge. While `dec_en` stays 1, the block stays armed and data reads still return the preset.
- R5: In `ST_HELD`, a read of LO_ADDR returns `snapshot[7:0]` and a read of LO_ADDR+1 returns `snapshot[15:8]`. The snapshot does not change while the counter keeps decrementing.
- R6: A read of the high byte (LO_ADDR+1) in `ST_HELD` leaves both `read_armed` and `snap_valid` at 1.
- R7: A read of the low byte in `ST_HELD` returns the snapshot byte in that same cycle and clears `read_armed` after the edge. Later reads return the preset.
- R8: A control write with `ctl_read_bit`=0 returns the block to `ST_IDLE` after the edge, from any state.
- R9: A read of any address other than the two data addresses returns 0 and does not change the state.
- R10: When the counter decrements freely and the host repeatedly arms and then reads the high byte followed by the low byte, no snapshot is ever larger than the one read before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, which is also the counter's clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Write strobe for the read bit of the control register |
| ctl_read_bit | input | 1 | Value written to the read bit |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 5 | Host read address |
| preset | input | 16 | The counter's preset (input) register |
| live_count | input | 16 | Current value of the counter |
| dec_en | input | 1 | 1 when the counter decrements at the next edge |
| rd_data | output | 8 | Read data byte |
| read_armed | output | 1 | Current value of the read bit |
| snap_valid | output | 1 | 1 while a snapshot is held |

## Verification
On every cycle, the assertions check the controller's transitions: arming, capture on a quiet cycle, waiting while the counter moves, release on a low-byte read, retention across a high-byte read, and abort. They also check that the snapshot stays frozen between captures and that preset bytes are returned while no snapshot is held. Only the bench scenarios can show that a captured value equals the count of the quiet cycle, and that reads of unmapped addresses return 0. They alone also show that repeated snapshots of a free-running countdown never increase, because that property spans many arm-and-read rounds.

// File: rtl/timer_snap_pkg.sv
package timer_snap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_HELD  = 2'd2
    } snap_state_e;
endpackage

// File: rtl/snap_ctrl_fsm.sv
module snap_ctrl_fsm
    import timer_snap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_we,
    input  logic        ctl_read_bit,
    input  logic        dec_en,
    input  logic        lo_rd,
    output snap_state_e state,
    output logic        capture
);
    snap_state_e state_nx;

    always_comb begin
        state_nx = state;
        if (ctl_we) begin
            state_nx = ctl_read_bit ? ST_ARMED : ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = ST_IDLE;
                ST_ARMED: if (!dec_en) state_nx = ST_HELD;
                ST_HELD:  if (lo_rd)   state_nx = ST_IDLE;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        capture = 1'b0;
        unique case (state)
            ST_ARMED: capture = !ctl_we && !dec_en;
            ST_IDLE,
            ST_HELD:  capture = 1'b0;
            default:  capture = 1'b0;
        endcase
    end

    a_r3_arm_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_read_bit) |=> (state == ST_ARMED));
    a_r4_capture_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && !dec_en && !ctl_we) |=> (state == ST_HELD));
    a_r4_wait_while_counting: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && dec_en && !ctl_we) |=> (state == ST_ARMED));
    a_r7_low_read_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HELD && lo_rd && !ctl_we) |=> (state == ST_IDLE));
    a_r8_write_zero_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && !ctl_read_bit) |=> (state == ST_IDLE));
endmodule

// File: rtl/snap_store.sv
module snap_store #(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [CNT_W-1:0] live_count,
    output logic [CNT_W-1:0] snap
);
    localparam int NBYTES = CNT_W / BYTE_W;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       snap[b*BYTE_W +: BYTE_W] <= '0;
            else if (capture) snap[b*BYTE_W +: BYTE_W] <= live_count[b*BYTE_W +: BYTE_W];
        end
    end

    a_r5_snapshot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(snap));
endmodule

// File: rtl/snap_read_mux.sv
module snap_read_mux #(
    parameter int             CNT_W   = 16,
    parameter int             BYTE_W  = 8,
    parameter int             ADDR_W  = 5,
    parameter logic [ADDR_W-1:0] LO_ADDR = 5'h0F
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              use_snap,
    input  logic [CNT_W-1:0]  snap,
    input  logic [CNT_W-1:0]  preset,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int NBYTES = CNT_W / BYTE_W;

    logic [NBYTES-1:0][BYTE_W-1:0] lane;
    logic [CNT_W-1:0]              src;

    assign src = use_snap ? snap : preset;

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign lane[b] = (rd_addr == ADDR_W'(LO_ADDR + b)) ? src[b*BYTE_W +: BYTE_W] : '0;
    end

    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NBYTES; b++) rd_data = rd_data | lane[b];
    end
endmodule

// File: rtl/timer_snap_read.sv
module timer_snap_read
    import timer_snap_pkg::*;
#(
    parameter int                CNT_W   = 16,
    parameter int                BYTE_W  = 8,
    parameter int                ADDR_W  = 5,
    parameter logic [ADDR_W-1:0] LO_ADDR = 5'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic              ctl_read_bit,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CNT_W-1:0]  preset,
    input  logic [CNT_W-1:0]  live_count,
    input  logic              dec_en,
    output logic [BYTE_W-1:0] rd_data,
    output logic              read_armed,
    output logic              snap_valid
);
    localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(LO_ADDR + (CNT_W / BYTE_W) - 1);

    snap_state_e      state;
    logic             capture;
    logic             lo_rd;
    logic [CNT_W-1:0] snap;

    assign lo_rd      = rd_en && (rd_addr == LO_ADDR);
    assign read_armed = (state != ST_IDLE);
    assign snap_valid = (state == ST_HELD);

    snap_ctrl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_we       (ctl_we),
        .ctl_read_bit (ctl_read_bit),
        .dec_en       (dec_en),
        .lo_rd        (lo_rd),
        .state        (state),
        .capture      (capture)
    );

    snap_store #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .live_count (live_count),
        .snap       (snap)
    );

    snap_read_mux #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR)) u_mux (
        .rd_addr  (rd_addr),
        .use_snap (snap_valid),
        .snap     (snap),
        .preset   (preset),
        .rd_data  (rd_data)
    );

    a_r2_preset_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!snap_valid && rd_en && rd_addr == LO_ADDR) |-> (rd_data == preset[BYTE_W-1:0]));
    a_r6_high_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_valid && rd_en && rd_addr == HI_ADDR && !ctl_we) |=> snap_valid);
endmodule

// File: tb/tb_timer_snap_read.sv
module tb_timer_snap_read;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0, ctl_read_bit = 1'b0, rd_en = 1'b0, dec_en = 1'b0;
    logic [4:0]  rd_addr = '0;
    logic [15:0] preset = 16'hA55A;
    logic [15:0] cnt = 16'h1234;
    logic [7:0]  rd_data;
    logic        read_armed, snap_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct { logic [7:0] val; string tag; } exp_t;
    exp_t q[$];

    localparam logic [4:0] LO = 5'h0F;
    localparam logic [4:0] HI = 5'h10;

    always #4 clk = ~clk;

    always @(posedge clk) if (rst_n && dec_en) cnt <= cnt - 16'd1;

    timer_snap_read dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_read_bit(ctl_read_bit),
        .rd_en(rd_en), .rd_addr(rd_addr), .preset(preset), .live_count(cnt),
        .dec_en(dec_en), .rd_data(rd_data), .read_armed(read_armed), .snap_valid(snap_valid)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rd_en && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(rd_data == e.val, e.tag, {24'd0, rd_data}, {24'd0, e.val});
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic do_read(input logic [4:0] a, input logic [7:0] exp, input string tag);
        exp_t e;
        e.val = exp;
        e.tag = tag;
        q.push_back(e);
        rd_en   = 1'b1;
        rd_addr = a;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic ctl_write(input bit v);
        ctl_we       = 1'b1;
        ctl_read_bit = v;
        tick();
        ctl_we = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        logic [15:0] exp_snap;
        logic [15:0] prev;
        logic [7:0]  hb;
        repeat (3) tick();
        check(read_armed == 1'b0 && snap_valid == 1'b0, "R1 reset state", {read_armed, snap_valid}, 0);
        rst_n = 1'b1;
        tick();
        check(read_armed == 1'b0, "R1 idle after reset", read_armed, 0);
        do_read(LO, 8'h5A, "R2 preset low");
        do_read(HI, 8'hA5, "R2 preset high");

        // R3 / R4: arm while counting, capture on quiet cycle
        dec_en = 1'b1;
        ctl_write(1'b1);
        check(read_armed == 1'b1, "R3 read bit set", read_armed, 1);
        do_read(LO, 8'h5A, "R4 armed read gives preset");
        check(snap_valid == 1'b0, "R4 no capture while counting", snap_valid, 0);
        dec_en   = 1'b0;
        exp_snap = cnt;
        tick();
        check(snap_valid == 1'b1, "R4 captured on quiet cycle", snap_valid, 1);
        dec_en = 1'b1;
        repeat (5) tick();
        do_read(HI, exp_snap[15:8], "R5 snapshot high");
        check(read_armed == 1'b1 && snap_valid == 1'b1, "R6 high read keeps bit", {read_armed, snap_valid}, 3);
        do_read(LO, exp_snap[7:0], "R5 R7 snapshot low");
        check(read_armed == 1'b0, "R7 low read clears bit", read_armed, 0);
        do_read(LO, 8'h5A, "R7 back to preset low");
        do_read(HI, 8'hA5, "R7 back to preset high");

        // R8: abort with a write of zero
        dec_en = 1'b0;
        ctl_write(1'b1);
        tick();
        check(snap_valid == 1'b1, "R8 setup held", snap_valid, 1);
        ctl_write(1'b0);
        check(read_armed == 1'b0, "R8 write zero clears", read_armed, 0);
        do_read(LO, 8'h5A, "R8 preset after abort");

        // R9: unmapped address
        exp_snap = cnt;
        ctl_write(1'b1);
        tick();
        do_read(5'h05, 8'h00, "R9 unmapped reads zero");
        check(snap_valid == 1'b1, "R9 unmapped read keeps state", snap_valid, 1);
        do_read(5'h11, 8'h00, "R9 next timer address reads zero");
        do_read(HI, exp_snap[15:8], "R9 snapshot high intact");
        do_read(LO, exp_snap[7:0], "R9 snapshot low intact");

        // R10: repeated snapshots of a free countdown never increase
        prev = 16'hFFFF;
        for (int i = 0; i < 20; i++) begin
            dec_en = (i % 3) != 0;
            ctl_write(1'b1);
            for (int w = 0; w < 4 && !snap_valid; w++) begin
                dec_en = (w % 2) == 1;
                tick();
            end
            dec_en  = 1'b1;
            rd_en   = 1'b1;
            rd_addr = HI;
            #1 hb = rd_data;
            tick();
            rd_addr = LO;
            #1 exp_snap = {hb, rd_data};
            tick();
            rd_en = 1'b0;
            check(exp_snap <= prev, "R10 snapshot not increasing", exp_snap, prev);
            prev = exp_snap;
        end
        check(read_armed == 1'b0, "R7 cleared after final low read", read_armed, 0);
        finish_run();
    end
endmodule